// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the fetch address of a 32-bit processor whose instructions are all one word long and sit on word boundaries. On every enabled clock edge it loads the next fetch address. That address comes from one of four places: the plain step to the following word, a conditional branch measured from the following word, a jump into the current 256 MiB region, or a full address taken from a register.

The decode stage gives the block three things: a 3-bit operation code, the branch condition result, and the raw instruction fields. The block returns the current address. For a link jump it also returns the return address, marked for write-back. A register jump to an address that is not word aligned is corrected by clearing the low two bits, and the block raises a flag in the same cycle.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` loads 0x00000000 at that edge.
- R2: While `en` is low and `rst` is low, `pc` keeps its value at the edge, whatever the other inputs are.
- R3: Operation code 0 (step), and codes 5, 6 and 7, load `pc` + 4. `br_taken` has no effect with these codes.
- R4: Operation code 1 (branch) with `br_taken` high loads `pc` + 4 + (`br_imm` sign-extended and multiplied by 4). The offset reaches from -32768 to +32767 words.
- R5: Operation code 1 with `br_taken` low loads `pc` + 4.
- R6: Operation code 2 (jump) loads bits 31:28 of `pc` + 4, followed by `jmp_field`, followed by two zero bits. The 26-bit field is unsigned and the current `pc` is not added to it.
- R7: Operation code 3 (jump and link) loads the same target as R6. In the same cycle `link_wr` is 1 and `link_addr` equals `pc` + 4. For every other code `link_wr` is 0.
- R8: Operation code 4 (register jump) loads `reg_op` with bits 1:0 cleared.
- R9: `align_err` is 1 in the same cycle exactly when the code is 4 and bits 1:0 of `reg_op` are not zero. Otherwise it is 0.
- R10: Bits 1:0 of `pc` are always zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low stalls the PC |
| ctrl | input | 3 | Operation code: 0 step, 1 branch, 2 jump, 3 jump and link, 4 register jump |
| br_taken | input | 1 | Branch condition result |
| br_imm | input | 16 | Signed branch offset in words |
| jmp_field | input | 26 | Unsigned jump word index |
| reg_op | input | 32 | Register operand for register jumps |
| pc | output | 32 | Current fetch address |
| link_addr | output | 32 | Return address (`pc` + 4) |
| link_wr | output | 1 | Write-back request for the return address |
| align_err | output | 1 | Register jump target was not word aligned |

## Verification
The next-address result shows up on `pc` one rising edge after the operation is presented with `en` high. `link_addr`, `link_wr` and `align_err` are combinational and are valid in the same cycle as their inputs. The bench drives each vector on a falling edge. It compares the same-cycle outputs shortly after that edge. It then waits for the rising edge, advances its own model PC, and compares `pc` with the model before the next vector is driven.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  parameter int PC_W = 32;
  parameter int BR_W = 16;
  parameter int JF_W = 26;
  localparam int SEXT_W = PC_W - BR_W - 2;
  localparam int SEG_W  = PC_W - JF_W - 2;

  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_BR   = 3'd1,
    OP_JMP  = 3'd2,
    OP_JAL  = 3'd3,
    OP_JREG = 3'd4
  } pc_op_e;

  function automatic logic [PC_W-1:0] f_step(input logic [PC_W-1:0] a);
    return a + PC_W'(4);
  endfunction

  function automatic logic [PC_W-1:0] f_branch(input logic [PC_W-1:0] base,
                                               input logic [BR_W-1:0] imm);
    return base + {{SEXT_W{imm[BR_W-1]}}, imm, 2'b00};
  endfunction

  function automatic logic [PC_W-1:0] f_jump(input logic [PC_W-1:0] base,
                                             input logic [JF_W-1:0] fld);
    return {base[PC_W-1 -: SEG_W], fld, 2'b00};
  endfunction

  function automatic logic [PC_W-1:0] f_regjump(input logic [PC_W-1:0] r);
    return {r[PC_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/pcseq_targets.sv
module pcseq_targets
  import pcseq_pkg::*;
(
  input  logic [PC_W-1:0] pc,
  input  logic [BR_W-1:0] br_imm,
  input  logic [JF_W-1:0] jmp_field,
  input  logic [PC_W-1:0] reg_op,
  output logic [PC_W-1:0] pc4,
  output logic [PC_W-1:0] br_tgt,
  output logic [PC_W-1:0] jmp_tgt,
  output logic [PC_W-1:0] jr_tgt,
  output logic            misaligned
);
  always_comb begin
    pc4        = f_step(pc);
    br_tgt     = f_branch(pc4, br_imm);
    jmp_tgt    = f_jump(pc4, jmp_field);
    jr_tgt     = f_regjump(reg_op);
    misaligned = |reg_op[1:0];
  end
endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
  import pcseq_pkg::*;
(
  input  logic [2:0]      ctrl,
  input  logic            br_taken,
  input  logic [PC_W-1:0] pc4,
  input  logic [PC_W-1:0] br_tgt,
  input  logic [PC_W-1:0] jmp_tgt,
  input  logic [PC_W-1:0] jr_tgt,
  input  logic            misaligned,
  output logic [PC_W-1:0] nxt_pc,
  output logic            link_wr,
  output logic            align_err
);
  pc_op_e op;

  always_comb begin
    op        = pc_op_e'(ctrl);
    nxt_pc    = pc4;
    link_wr   = 1'b0;
    align_err = 1'b0;
    case (op)
      OP_BR:   if (br_taken) nxt_pc = br_tgt;
      OP_JMP:  nxt_pc = jmp_tgt;
      OP_JAL:  begin
        nxt_pc  = jmp_tgt;
        link_wr = 1'b1;
      end
      OP_JREG: begin
        nxt_pc    = jr_tgt;
        align_err = misaligned;
      end
      default: nxt_pc = pc4;
    endcase
  end
endmodule

// File: rtl/pcseq_pcreg.sv
module pcseq_pcreg
  import pcseq_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RESET_VEC;
    else if (en) q <= d;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [2:0]      ctrl,
  input  logic            br_taken,
  input  logic [BR_W-1:0] br_imm,
  input  logic [JF_W-1:0] jmp_field,
  input  logic [PC_W-1:0] reg_op,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] link_addr,
  output logic            link_wr,
  output logic            align_err
);
  logic [PC_W-1:0] pc4, br_tgt, jmp_tgt, jr_tgt, nxt_pc;
  logic            misaligned;

  pcseq_targets u_tgt (
    .pc(pc), .br_imm(br_imm), .jmp_field(jmp_field), .reg_op(reg_op),
    .pc4(pc4), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt), .jr_tgt(jr_tgt),
    .misaligned(misaligned)
  );

  pcseq_select u_sel (
    .ctrl(ctrl), .br_taken(br_taken), .pc4(pc4), .br_tgt(br_tgt),
    .jmp_tgt(jmp_tgt), .jr_tgt(jr_tgt), .misaligned(misaligned),
    .nxt_pc(nxt_pc), .link_wr(link_wr), .align_err(align_err)
  );

  pcseq_pcreg #(.RESET_VEC(RESET_VEC)) u_pc (
    .clk(clk), .rst(rst), .en(en), .d(nxt_pc), .q(pc)
  );

  assign link_addr = pc4;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker
  import pcseq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic [2:0]      ctrl,
  input logic            br_taken,
  input logic [PC_W-1:0] reg_op,
  input logic [PC_W-1:0] pc,
  input logic [PC_W-1:0] link_addr,
  input logic            link_wr,
  input logic            align_err,
  input logic [PC_W-1:0] br_tgt
);
  a_r1_reset_vector: assert property (@(posedge clk)
    rst |=> pc == '0);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc));

  a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (en && ctrl == OP_BR && br_taken) |=> pc == $past(br_tgt));

  a_r5_branch_fallthru: assert property (@(posedge clk) disable iff (rst)
    (en && ctrl == OP_BR && !br_taken) |=> pc == $past(pc) + PC_W'(4));

  a_r7_link_out: assert property (@(posedge clk) disable iff (rst)
    (ctrl == OP_JAL) |-> (link_wr && link_addr == pc + PC_W'(4)));

  a_r8_regjump: assert property (@(posedge clk) disable iff (rst)
    (en && ctrl == OP_JREG) |=> pc == {$past(reg_op[PC_W-1:2]), 2'b00});

  a_r9_align_flag: assert property (@(posedge clk) disable iff (rst)
    align_err |-> (ctrl == OP_JREG && reg_op[1:0] != 2'b00));

  a_r10_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);
endmodule

bind pc_sequencer pcseq_checker u_chk (
  .clk(clk), .rst(rst), .en(en), .ctrl(ctrl), .br_taken(br_taken),
  .reg_op(reg_op), .pc(pc), .link_addr(link_addr), .link_wr(link_wr),
  .align_err(align_err), .br_tgt(br_tgt)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst, en, br_taken;
  logic [2:0]  ctrl;
  logic [15:0] br_imm;
  logic [25:0] jmp_field;
  logic [31:0] reg_op;
  logic [31:0] pc, link_addr;
  logic        link_wr, align_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  longint unsigned mpc = 0;

  pc_sequencer dut (
    .clk(clk), .rst(rst), .en(en), .ctrl(ctrl), .br_taken(br_taken),
    .br_imm(br_imm), .jmp_field(jmp_field), .reg_op(reg_op), .pc(pc),
    .link_addr(link_addr), .link_wr(link_wr), .align_err(align_err)
  );

  always #2 clk = ~clk;

  task automatic cmp(input string req, input string what,
                     input longint unsigned got, input longint unsigned exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  // Reference: next address computed from integer arithmetic on the requirement text
  function automatic longint unsigned model_next(input int op, input bit tk,
      input logic [15:0] imm, input logic [25:0] fld, input logic [31:0] r);
    longint unsigned nx = (mpc + 4) % 64'h1_0000_0000;
    longint signed off;
    case (op)
      1: if (tk) begin
           off = longint'($signed(imm)) * 4;
           nx = longint'(nx + off) & 64'hFFFF_FFFF;
         end
      2, 3: nx = (nx & 64'hF000_0000) + longint'(fld) * 4;
      4: nx = longint'(r) - (longint'(r) % 4);
      default: ;
    endcase
    return nx;
  endfunction

  task automatic step(input string req, input bit e, input int op, input bit tk,
      input logic [15:0] imm, input logic [25:0] fld, input logic [31:0] r);
    en = e; ctrl = 3'(op); br_taken = tk; br_imm = imm; jmp_field = fld; reg_op = r;
    #1;
    cmp("R7", "link_addr", link_addr, (mpc + 4) % 64'h1_0000_0000);
    cmp("R7", "link_wr", link_wr, (op == 3) ? 1 : 0);
    cmp("R9", "align_err", align_err, (op == 4 && (r % 4) != 0) ? 1 : 0);
    if (e) mpc = model_next(op, tk, imm, fld, r);
    @(posedge clk);
    @(negedge clk);
    cmp(req, "pc", pc, mpc);
    cmp("R10", "pc low bits", pc % 4, 0);
  endtask

  initial begin
    rst = 1; en = 0; ctrl = 0; br_taken = 0; br_imm = 0; jmp_field = 0; reg_op = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    cmp("R1", "pc after reset", pc, 0);
    rst = 0; mpc = 0;

    step("R3", 1, 0, 0, 16'h0, 26'h0, 32'h0);
    step("R3", 1, 0, 1, 16'hFFFF, 26'h3FF_FFFF, 32'hDEAD_BEEF);  // taken ignored
    step("R3", 1, 5, 1, 16'h0010, 26'h1, 32'h0);
    step("R3", 1, 7, 0, 16'h0, 26'h2, 32'h0);
    step("R4", 1, 1, 1, 16'h0004, 26'h0, 32'h0);
    step("R4", 1, 1, 1, 16'h7FFF, 26'h0, 32'h0);                // max forward
    step("R5", 1, 1, 0, 16'h7FFF, 26'h0, 32'h0);
    step("R8", 1, 4, 0, 16'h0, 26'h0, 32'h8000_0000);
    step("R4", 1, 1, 1, 16'h8000, 26'h0, 32'h0);                // max backward
    step("R4", 1, 1, 1, 16'hFFFF, 26'h0, 32'h0);                // -1 word
    step("R2", 0, 2, 1, 16'h0, 26'h155_5555, 32'h0);             // stalled jump
    step("R2", 0, 4, 0, 16'h0, 26'h0, 32'h1234_5678);
    step("R6", 1, 2, 1, 16'h0, 26'h155_5555, 32'h0);
    step("R8", 1, 4, 0, 16'h0, 26'h0, 32'hFFFF_FFF7);            // misaligned
    step("R6", 1, 2, 0, 16'h0, 26'h3FF_FFFF, 32'h0);              // region carry at top
    step("R7", 1, 3, 0, 16'h0, 26'h000_0100, 32'h0);
    step("R8", 1, 4, 0, 16'h0, 26'h0, 32'h0040_0002);
    step("R8", 1, 4, 1, 16'h0, 26'h0, 32'h0040_1001);
    step("R7", 1, 3, 1, 16'h1234, 26'h2AA_AAAA, 32'h3);
    step("R5", 1, 1, 0, 16'h8000, 26'h0, 32'h0);
    step("R3", 1, 6, 1, 16'h8000, 26'h0, 32'h0);
    for (int i = 0; i < 40; i++)
      step("R4", 1, 1, i[0], 16'(i * 977 - 9000), 26'h0, 32'h0);

    rst = 1;
    @(posedge clk); @(negedge clk);
    cmp("R1", "pc after mid reset", pc, 0);
    rst = 0; mpc = 0;
    step("R3", 1, 0, 0, 16'h0, 26'h0, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog run did not complete got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule